// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions of an out-of-order core in program order until they are allowed to change architectural state. Each instruction takes an entry at issue, and the index of that entry serves as the tag under which its result is later broadcast. The buffer also holds a per-register table of the newest pending producer. Issue logic looks up this table and the entry contents together, so it can read a finished but not yet committed value, or learn which tag to wait for.

There are three kinds of entry. A register operation writes the register file when it retires. A store sends its address and data to memory when it retires, and its data may arrive on the result bus after issue. A branch writes nothing. A branch that resolved as mispredicted empties the whole buffer when it reaches the head, and it drives a redirect target toward fetch. One entry can retire per cycle, and only from the head.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the buffer is empty. `iss_ready` is 1, `iss_tag` is 0, `rf_we`, `st_we` and `redirect_valid` are 0, and every register lookup reports not busy.
- R2: An accepted issue (`iss_valid` and `iss_ready`) takes the entry shown on `iss_tag`. Successive accepted issues get consecutive tags modulo ENTRIES, and the count restarts at 0 after a flush.
- R3: Once ENTRIES entries are held, `iss_ready` is 0. An issue attempt made while `iss_ready` is 0 changes nothing: the tag does not advance and the register table is not marked.
- R4: A result broadcast with `cdb_valid` writes `cdb_value` into the entry named by `cdb_tag` and marks it ready. A lookup of a register whose newest producer is that entry then returns ready with that value.
- R5: Entries retire strictly in allocation order. A ready register operation (`iss_kind` 0) at the head drives `rf_we` for one cycle with its destination register and value. A ready younger entry waits behind a head that is not ready.
- R6: A store (`iss_kind` 1) whose data was present at issue (`iss_data_ok`) retires from the head by driving `st_we` with its address and data, and it never drives `rf_we`.
- R7: A store issued without data takes its data from the first broadcast whose tag equals `iss_data_tag`. This includes a broadcast in the same cycle as the store's own issue. Only after that does it retire through `st_we`.
- R8: A branch (`iss_kind` 2) resolved with `cdb_mispredict` 1 drives `redirect_valid` with `redirect_target` equal to the broadcast value when it reaches the head. In that cycle `iss_ready` is 0. Afterwards the buffer is empty, all register entries read not busy, and no younger entry ever commits.
- R9: A branch resolved with `cdb_mispredict` 0 retires from the head without any register write, store or redirect. The next entry commits in the following cycle.
- R10: Issue of a register operation marks its destination busy with the new tag. Lookups return that busy bit and tag.
- R11: When a register operation retires, the busy mark of its destination is cleared only if the table still names the retiring entry. If a newer producer of the same register exists, the mark stays, pointing at the newer tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | 0 register op, 1 store, 2 branch |
| iss_dreg | input | RW | Destination register of a register op |
| iss_addr | input | AW | Store address |
| iss_data_ok | input | 1 | Store data present at issue |
| iss_data | input | XLEN | Store data when present |
| iss_data_tag | input | IW | Producer tag of missing store data |
| iss_ready | output | 1 | A free entry exists and no flush is under way |
| iss_tag | output | IW | Entry index granted to this issue |
| src_reg | input | NSRC*RW | Registers looked up for operands |
| src_busy | output | NSRC | Register has a pending producer |
| src_tag | output | NSRC*IW | Tag of that producer |
| src_ready | output | NSRC | Producer's result is already held |
| src_value | output | NSRC*XLEN | Held result |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | IW | Entry the result belongs to |
| cdb_value | input | XLEN | Result value, or branch target |
| cdb_mispredict | input | 1 | Branch outcome was mispredicted |
| rf_we | output | 1 | Register file write |
| rf_addr | output | RW | Register written |
| rf_data | output | XLEN | Value written |
| st_we | output | 1 | Memory store |
| st_addr | output | AW | Store address |
| st_data | output | XLEN | Store data |
| redirect_valid | output | 1 | Flush and restart fetch |
| redirect_target | output | XLEN | Restart address |

## Verification
The hardest case to reach is a store whose data producer broadcasts in the very cycle the store itself issues. Without a bypass at allocation, that store would wait forever. The bench drives the store issue and the producer's broadcast in the same cycle and then checks the store's retire data. The mispredict case is also arranged with care: a younger register op is made ready behind an unresolved branch, the branch then resolves as mispredicted, and an issue attempt is driven during the flush cycle. The bench then checks that neither the younger op nor the dropped issue leaves any trace.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OP_REG    = 2'd0,
        OP_STORE  = 2'd1,
        OP_BRANCH = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        RET_NONE,
        RET_REG,
        RET_STORE,
        RET_BR_OK,
        RET_FLUSH
    } retire_e;

    function automatic retire_e retire_action(input logic valid, input logic ready,
                                              input op_kind_e kind, input logic mis);
        retire_e a;
        a = RET_NONE;
        if (valid && ready) begin
            case (kind)
                OP_REG:    a = RET_REG;
                OP_STORE:  a = RET_STORE;
                OP_BRANCH: a = mis ? RET_FLUSH : RET_BR_OK;
                default:   a = RET_NONE;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic          retire,
    input  logic          flush,
    output logic [IW-1:0] head_idx,
    output logic [IW-1:0] tail_idx,
    output logic          full
);
    logic [IW:0] head_q, tail_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + {{IW{1'b0}}, retire};
            tail_q <= tail_q + {{IW{1'b0}}, alloc};
        end
    end

    assign head_idx = head_q[IW-1:0];
    assign tail_idx = tail_q[IW-1:0];
    assign full     = (head_q[IW] != tail_q[IW]) && (head_idx == tail_idx);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    parameter int RW      = 5,
    parameter int AW      = 32,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           alloc_en,
    input  logic [IW-1:0]                  alloc_idx,
    input  op_kind_e                       alloc_kind,
    input  logic [RW-1:0]                  alloc_dreg,
    input  logic [AW-1:0]                  alloc_addr,
    input  logic                           alloc_data_ok,
    input  logic [XLEN-1:0]                alloc_data,
    input  logic [IW-1:0]                  alloc_data_tag,
    input  logic                           cdb_valid,
    input  logic [IW-1:0]                  cdb_tag,
    input  logic [XLEN-1:0]                cdb_value,
    input  logic                           cdb_mispredict,
    input  logic                           retire_en,
    input  logic [IW-1:0]                  retire_idx,
    output logic [ENTRIES-1:0]             ent_valid,
    output logic [ENTRIES-1:0]             ent_ready,
    output logic [ENTRIES-1:0]             ent_mis,
    output logic [ENTRIES-1:0][1:0]        ent_kind,
    output logic [ENTRIES-1:0][XLEN-1:0]   ent_value,
    output logic [ENTRIES-1:0][RW-1:0]     ent_dreg,
    output logic [ENTRIES-1:0][AW-1:0]     ent_addr
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam logic [IW-1:0] MY = IW'(i);
        logic [IW-1:0] wait_tag;
        logic          bypass;

        assign bypass = cdb_valid && (cdb_tag == alloc_data_tag);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ent_valid[i] <= 1'b0;
                ent_ready[i] <= 1'b0;
                ent_mis[i]   <= 1'b0;
            end else if (alloc_en && alloc_idx == MY) begin
                ent_valid[i] <= 1'b1;
                ent_kind[i]  <= alloc_kind;
                ent_dreg[i]  <= alloc_dreg;
                ent_addr[i]  <= alloc_addr;
                ent_mis[i]   <= 1'b0;
                wait_tag     <= alloc_data_tag;
                if (alloc_kind == OP_STORE && alloc_data_ok) begin
                    ent_value[i] <= alloc_data;
                    ent_ready[i] <= 1'b1;
                end else if (alloc_kind == OP_STORE && bypass) begin
                    ent_value[i] <= cdb_value;
                    ent_ready[i] <= 1'b1;
                end else begin
                    ent_value[i] <= '0;
                    ent_ready[i] <= 1'b0;
                end
            end else if (ent_valid[i]) begin
                if (retire_en && retire_idx == MY) begin
                    ent_valid[i] <= 1'b0;
                    ent_ready[i] <= 1'b0;
                end else if (cdb_valid && !ent_ready[i]) begin
                    if (ent_kind[i] != OP_STORE && cdb_tag == MY) begin
                        ent_value[i] <= cdb_value;
                        ent_mis[i]   <= cdb_mispredict;
                        ent_ready[i] <= 1'b1;
                    end else if (ent_kind[i] == OP_STORE && cdb_tag == wait_tag) begin
                        ent_value[i] <= cdb_value;
                        ent_ready[i] <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rob_reg_status.sv
module rob_reg_status #(
    parameter int NREG    = 32,
    parameter int ENTRIES = 8,
    parameter int NSRC    = 2,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      set_en,
    input  logic [RW-1:0]             set_reg,
    input  logic [IW-1:0]             set_tag,
    input  logic                      clr_en,
    input  logic [RW-1:0]             clr_reg,
    input  logic [IW-1:0]             clr_tag,
    input  logic [NSRC-1:0][RW-1:0]   look_reg,
    output logic [NSRC-1:0]           look_busy,
    output logic [NSRC-1:0][IW-1:0]   look_tag
);
    logic [NREG-1:0]          busy_q;
    logic [NREG-1:0][IW-1:0]  tag_q;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [RW-1:0] MY = RW'(r);
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                busy_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (set_en && set_reg == MY) begin
                busy_q[r] <= 1'b1;
                tag_q[r]  <= set_tag;
            end else if (clr_en && clr_reg == MY && tag_q[r] == clr_tag) begin
                busy_q[r] <= 1'b0;
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_look
        assign look_busy[s] = busy_q[look_reg[s]];
        assign look_tag[s]  = tag_q[look_reg[s]];
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int XLEN    = 32,
    parameter int NREG    = 32,
    parameter int AW      = 32,
    parameter int NSRC    = 2,
    localparam int IW = $clog2(ENTRIES),
    localparam int RW = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    input  logic [1:0]                 iss_kind,
    input  logic [RW-1:0]              iss_dreg,
    input  logic [AW-1:0]              iss_addr,
    input  logic                       iss_data_ok,
    input  logic [XLEN-1:0]            iss_data,
    input  logic [IW-1:0]              iss_data_tag,
    output logic                       iss_ready,
    output logic [IW-1:0]              iss_tag,
    input  logic [NSRC-1:0][RW-1:0]    src_reg,
    output logic [NSRC-1:0]            src_busy,
    output logic [NSRC-1:0][IW-1:0]    src_tag,
    output logic [NSRC-1:0]            src_ready,
    output logic [NSRC-1:0][XLEN-1:0]  src_value,
    input  logic                       cdb_valid,
    input  logic [IW-1:0]              cdb_tag,
    input  logic [XLEN-1:0]            cdb_value,
    input  logic                       cdb_mispredict,
    output logic                       rf_we,
    output logic [RW-1:0]              rf_addr,
    output logic [XLEN-1:0]            rf_data,
    output logic                       st_we,
    output logic [AW-1:0]              st_addr,
    output logic [XLEN-1:0]            st_data,
    output logic                       redirect_valid,
    output logic [XLEN-1:0]            redirect_target
);
    logic [IW-1:0]                 head_idx, tail_idx;
    logic                          full, alloc_en, retire_en, flush;
    op_kind_e                      kind_in;
    retire_e                       action;
    logic [ENTRIES-1:0]            ent_valid, ent_ready, ent_mis;
    logic [ENTRIES-1:0][1:0]       ent_kind;
    logic [ENTRIES-1:0][XLEN-1:0]  ent_value;
    logic [ENTRIES-1:0][RW-1:0]    ent_dreg;
    logic [ENTRIES-1:0][AW-1:0]    ent_addr;

    assign kind_in   = op_kind_e'(iss_kind);
    assign action    = retire_action(ent_valid[head_idx], ent_ready[head_idx],
                                     op_kind_e'(ent_kind[head_idx]), ent_mis[head_idx]);
    assign retire_en = (action != RET_NONE);
    assign flush     = (action == RET_FLUSH);
    assign iss_ready = !full && !flush;
    assign alloc_en  = iss_valid && iss_ready;
    assign iss_tag   = tail_idx;

    rob_ptr_ctrl #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst(rst), .alloc(alloc_en), .retire(retire_en), .flush(flush),
        .head_idx(head_idx), .tail_idx(tail_idx), .full(full)
    );

    rob_entry_array #(.ENTRIES(ENTRIES), .XLEN(XLEN), .RW(RW), .AW(AW)) u_ent (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_en(alloc_en), .alloc_idx(tail_idx), .alloc_kind(kind_in),
        .alloc_dreg(iss_dreg), .alloc_addr(iss_addr), .alloc_data_ok(iss_data_ok),
        .alloc_data(iss_data), .alloc_data_tag(iss_data_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_mispredict(cdb_mispredict),
        .retire_en(retire_en), .retire_idx(head_idx),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_mis(ent_mis),
        .ent_kind(ent_kind), .ent_value(ent_value), .ent_dreg(ent_dreg), .ent_addr(ent_addr)
    );

    rob_reg_status #(.NREG(NREG), .ENTRIES(ENTRIES), .NSRC(NSRC)) u_stat (
        .clk(clk), .rst(rst), .flush(flush),
        .set_en(alloc_en && kind_in == OP_REG), .set_reg(iss_dreg), .set_tag(tail_idx),
        .clr_en(action == RET_REG), .clr_reg(ent_dreg[head_idx]), .clr_tag(head_idx),
        .look_reg(src_reg), .look_busy(src_busy), .look_tag(src_tag)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_ready[s] = src_busy[s] && ent_ready[src_tag[s]];
        assign src_value[s] = ent_value[src_tag[s]];
    end

    assign rf_we           = (action == RET_REG);
    assign rf_addr         = ent_dreg[head_idx];
    assign rf_data         = ent_value[head_idx];
    assign st_we           = (action == RET_STORE);
    assign st_addr         = ent_addr[head_idx];
    assign st_data         = ent_value[head_idx];
    assign redirect_valid  = flush;
    assign redirect_target = ent_value[head_idx];
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input logic          clk,
    input logic          rst,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [IW-1:0] iss_tag,
    input logic          rf_we,
    input logic          st_we,
    input logic          redirect_valid
);
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (iss_ready && iss_tag == '0 && !rf_we && !st_we && !redirect_valid));

    a_r2_tag_advance: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> (iss_tag == IW'($past(iss_tag) + IW'(1))));

    a_r3_hold_when_blocked: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && !redirect_valid) |=> $stable(iss_tag));

    a_r5_one_retire_kind: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we, st_we, redirect_valid}));

    a_r8_flush_blocks_issue: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !iss_ready);

    a_r8_empty_after_flush: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> (iss_ready && iss_tag == '0 && !rf_we && !st_we && !redirect_valid));
endmodule

bind rob_core rob_core_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .rf_we(rf_we), .st_we(st_we), .redirect_valid(redirect_valid)
);

// File: tb/tb_rob_core.sv
module tb_rob_core;
    localparam int ENTRIES = 8;
    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int AW      = 32;
    localparam int NSRC    = 2;
    localparam int IW      = $clog2(ENTRIES);
    localparam int RW      = $clog2(NREG);

    logic clk = 1'b0;
    logic rst;
    logic iss_valid, iss_data_ok, iss_ready, cdb_valid, cdb_mispredict;
    logic [1:0] iss_kind;
    logic [RW-1:0] iss_dreg, rf_addr;
    logic [AW-1:0] iss_addr, st_addr;
    logic [XLEN-1:0] iss_data, cdb_value, rf_data, st_data, redirect_target;
    logic [IW-1:0] iss_data_tag, iss_tag, cdb_tag;
    logic [NSRC-1:0][RW-1:0] src_reg;
    logic [NSRC-1:0] src_busy, src_ready;
    logic [NSRC-1:0][IW-1:0] src_tag;
    logic [NSRC-1:0][XLEN-1:0] src_value;
    logic rf_we, st_we, redirect_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rob_core #(.ENTRIES(ENTRIES), .XLEN(XLEN), .NREG(NREG), .AW(AW), .NSRC(NSRC)) dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dreg(iss_dreg),
        .iss_addr(iss_addr), .iss_data_ok(iss_data_ok), .iss_data(iss_data),
        .iss_data_tag(iss_data_tag), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .src_reg(src_reg), .src_busy(src_busy), .src_tag(src_tag), .src_ready(src_ready),
        .src_value(src_value), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_mispredict(cdb_mispredict), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data), .redirect_valid(redirect_valid),
        .redirect_target(redirect_target)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // next sampling window: just after a falling edge, drives cleared
    task automatic win();
        @(negedge clk);
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        cdb_mispredict = 1'b0;
    endtask

    task automatic drive_issue(input logic [1:0] kind, input int dreg, input int addr,
                               input logic dok, input int data, input int dtag);
        iss_valid    = 1'b1;
        iss_kind     = kind;
        iss_dreg     = RW'(dreg);
        iss_addr     = AW'(addr);
        iss_data_ok  = dok;
        iss_data     = XLEN'(data);
        iss_data_tag = IW'(dtag);
    endtask

    task automatic drive_cdb(input int tag, input int val, input logic mis);
        cdb_valid      = 1'b1;
        cdb_tag        = IW'(tag);
        cdb_value      = XLEN'(val);
        cdb_mispredict = mis;
    endtask

    task automatic t_reset();
        #1;
        src_reg[0] = 5'd1; src_reg[1] = 5'd31;
        #1;
        chk("R1 iss_ready", 64'(iss_ready), 64'd1);
        chk("R1 iss_tag", 64'(iss_tag), 64'd0);
        chk("R1 no retire", 64'({rf_we, st_we, redirect_valid}), 64'd0);
        chk("R1 lookup idle", 64'(src_busy), 64'd0);
    endtask

    task automatic t_fill_and_order();
        for (int i = 0; i < ENTRIES; i++) begin
            drive_issue(2'd0, i + 1, 0, 1'b0, 0, 0);
            #1;
            chk("R2 consecutive tag", 64'(iss_tag), 64'(i));
            chk("R3 ready below full", 64'(iss_ready), 64'd1);
            win();
        end
        drive_issue(2'd0, 9, 0, 1'b0, 0, 0);
        src_reg[0] = 5'd1; src_reg[1] = 5'd8;
        #1;
        chk("R3 full blocks", 64'(iss_ready), 64'd0);
        chk("R10 busy r1", 64'(src_busy[0]), 64'd1);
        chk("R10 tag r1", 64'(src_tag[0]), 64'd0);
        chk("R10 tag r8", 64'(src_tag[1]), 64'd7);
        win();
        src_reg[0] = 5'd9;
        #1;
        chk("R3 dropped issue unmarked", 64'(src_busy[0]), 64'd0);
        chk("R3 tag held", 64'(iss_tag), 64'd0);
        for (int t = ENTRIES - 1; t >= 1; t--) begin
            drive_cdb(t, 32'h100 + t, 1'b0);
            #1;
            chk("R5 waits for head", 64'(rf_we), 64'd0);
            win();
        end
        src_reg[1] = 5'd8;
        drive_cdb(0, 32'h100, 1'b0);
        #1;
        chk("R4 lookup ready", 64'(src_ready[1]), 64'd1);
        chk("R4 lookup value", 64'(src_value[1]), 64'h107);
        chk("R5 head not yet ready", 64'(rf_we), 64'd0);
        win();
        for (int i = 1; i <= ENTRIES; i++) begin
            #1;
            chk("R5 rf_we", 64'(rf_we), 64'd1);
            chk("R5 rf_addr order", 64'(rf_addr), 64'(i));
            chk("R5 rf_data", 64'(rf_data), 64'(32'h100 + i - 1));
            win();
        end
        src_reg[0] = 5'd1; src_reg[1] = 5'd8;
        #1;
        chk("R5 drained", 64'(rf_we), 64'd0);
        chk("R11 busy cleared", 64'(src_busy), 64'd0);
    endtask

    task automatic t_rename_clear();
        drive_issue(2'd0, 5, 0, 1'b0, 0, 0);
        #1; chk("R2 tag wraps", 64'(iss_tag), 64'd0);
        win();
        drive_issue(2'd0, 5, 0, 1'b0, 0, 0);
        #1; chk("R2 tag", 64'(iss_tag), 64'd1);
        win();
        src_reg[0] = 5'd5;
        drive_cdb(0, 32'hA, 1'b0);
        #1; chk("R10 newest producer", 64'(src_tag[0]), 64'd1);
        win();
        #1;
        chk("R5 first r5 write", 64'({rf_we, rf_addr, rf_data}), 64'({1'b1, 5'd5, 32'hA}));
        win();
        #1;
        chk("R11 still busy", 64'(src_busy[0]), 64'd1);
        chk("R11 newer tag kept", 64'(src_tag[0]), 64'd1);
        drive_cdb(1, 32'hB, 1'b0);
        win();
        #1; chk("R5 second r5 write", 64'({rf_we, rf_data}), 64'({1'b1, 32'hB}));
        win();
        #1; chk("R11 cleared by match", 64'(src_busy[0]), 64'd0);
    endtask

    task automatic t_stores();
        drive_issue(2'd0, 3, 0, 1'b0, 0, 0);
        #1; chk("R2 tag", 64'(iss_tag), 64'd2);
        win();
        drive_issue(2'd1, 0, 32'h100, 1'b0, 0, 2);
        win();
        #1; chk("R7 store waits", 64'(st_we), 64'd0);
        drive_cdb(2, 32'h77, 1'b0);
        win();
        #1;
        chk("R5 producer commit", 64'({rf_we, rf_addr, rf_data}), 64'({1'b1, 5'd3, 32'h77}));
        chk("R6 store behind", 64'(st_we), 64'd0);
        win();
        #1;
        chk("R7 late data store", 64'({st_we, rf_we}), 64'({1'b1, 1'b0}));
        chk("R7 store addr", 64'(st_addr), 64'h100);
        chk("R7 store data", 64'(st_data), 64'h77);
        win();
        drive_issue(2'd0, 4, 0, 1'b0, 0, 0);
        #1; chk("R2 tag", 64'(iss_tag), 64'd4);
        win();
        drive_issue(2'd1, 0, 32'h180, 1'b0, 0, 4);
        drive_cdb(4, 32'h99, 1'b0);
        win();
        #1; chk("R5 bypass producer", 64'({rf_we, rf_data}), 64'({1'b1, 32'h99}));
        win();
        #1;
        chk("R7 same-cycle capture", 64'({st_we, st_addr, st_data}),
            64'({1'b1, 32'h180, 32'h99}));
        win();
        drive_issue(2'd1, 0, 32'h200, 1'b1, 32'h55, 0);
        #1; chk("R2 tag", 64'(iss_tag), 64'd6);
        win();
        #1;
        chk("R6 store with data", 64'({st_we, rf_we, st_addr, st_data}),
            64'({1'b1, 1'b0, 32'h200, 32'h55}));
        win();
    endtask

    task automatic t_branch_ok();
        drive_issue(2'd2, 0, 0, 1'b0, 0, 0);
        #1; chk("R2 tag", 64'(iss_tag), 64'd7);
        win();
        drive_issue(2'd0, 10, 0, 1'b0, 0, 0);
        win();
        drive_cdb(0, 32'h1234, 1'b0);
        win();
        #1; chk("R9 younger waits for branch", 64'(rf_we), 64'd0);
        drive_cdb(7, 32'hDEAD, 1'b0);
        win();
        #1;
        chk("R9 silent branch retire", 64'({rf_we, st_we, redirect_valid}), 64'd0);
        win();
        #1;
        chk("R9 next commits", 64'({rf_we, rf_addr, rf_data}), 64'({1'b1, 5'd10, 32'h1234}));
        win();
    endtask

    task automatic t_mispredict();
        drive_issue(2'd2, 0, 0, 1'b0, 0, 0);
        #1; chk("R2 tag", 64'(iss_tag), 64'd1);
        win();
        drive_issue(2'd0, 7, 0, 1'b0, 0, 0);
        win();
        drive_issue(2'd1, 0, 32'h300, 1'b1, 32'h66, 0);
        win();
        drive_cdb(2, 32'h42, 1'b0);
        win();
        drive_cdb(1, 32'h4000, 1'b1);
        win();
        drive_issue(2'd0, 12, 0, 1'b0, 0, 0);
        #1;
        chk("R8 redirect", 64'(redirect_valid), 64'd1);
        chk("R8 target", 64'(redirect_target), 64'h4000);
        chk("R8 issue blocked", 64'(iss_ready), 64'd0);
        chk("R8 no write on flush", 64'({rf_we, st_we}), 64'd0);
        win();
        src_reg[0] = 5'd7; src_reg[1] = 5'd12;
        #1;
        chk("R8 emptied", 64'({iss_ready, iss_tag}), 64'({1'b1, 3'd0}));
        chk("R8 no younger commit", 64'({rf_we, st_we, redirect_valid}), 64'd0);
        chk("R8 table cleared", 64'(src_busy), 64'd0);
        win();
        #1;
        chk("R8 store squashed", 64'({rf_we, st_we}), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        iss_valid = 1'b0; iss_kind = '0; iss_dreg = '0; iss_addr = '0;
        iss_data_ok = 1'b0; iss_data = '0; iss_data_tag = '0;
        cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_mispredict = 1'b0;
        src_reg = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        win();
        t_fill_and_order();
        win();
        t_rename_clear();
        win();
        t_stores();
        t_branch_ok();
        t_mispredict();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule